// File: doc/BRIEF.md
# Sticky Flag Interrupt Controller

This block gathers per-lane loss-of-signal and transmit-fault events, plus alarm events from monitored values that it compares against high and low thresholds. Each event is captured in a flag bit that stays set until the host reads the register holding it. Every flag has its own mask bit. A single active-low interrupt output pulls low while any unmasked flag is set. The output is meant to drive an open-drain pad, which pulls low when the output is 0 and floats otherwise.

The block also sequences initialization. After a power-on reset, or after a long enough low pulse on the module reset pin, it raises a not-ready status bit and holds every flag at zero. When initialization ends it clears not-ready and posts a completion interrupt, which the host acknowledges by reading the status register. Flag registers are read through a strobe with a register index. Mask registers are written through a separate strobe.

Top module: `flag_irq_ctrl`

## Requirements
- R1: A flag bit is set in the cycle after its event input is high. It stays set after the event falls, until its register is read or a reset occurs.
- R2: A read of index 0 (loss of signal, bit n = lane n), index 1 (transmit fault, bit n = lane n) or index 2 (monitor alarms) returns that register's flags in `rd_data` in the same cycle. The read clears exactly the returned bits at the next edge, except that a bit whose event is high in the read cycle stays set.
- R3: A read of one flag register leaves the flags of every other register unchanged.
- R4: A masked flag (mask bit 1) still latches and reads back but does not pull the interrupt low. Clearing the mask bit while the flag is set pulls `irq_n` low within two cycles.
- R5: `irq_n` goes low one cycle after any unmasked flag is set. It returns high one cycle after the last unmasked flag and the completion flag are cleared.
- R6: For monitor m, bit 2m of index 2 sets when the value is strictly greater than its high threshold. Bit 2m+1 sets when the value is strictly less than its low threshold. A value equal to a threshold sets nothing.
- R7: A low pulse on `mod_rst_n` lasting at most RST_MIN_CYC cycles has no effect. A longer pulse, on release, clears all flags, returns every mask to its default and raises not-ready.
- R8: While not-ready is 1, events are ignored, all flags read as zero and `irq_n` stays high.
- R9: INIT_CYC cycles after a reset, not-ready falls and `irq_n` goes low. Reading index 3 returns bit 0 = not-ready and bit 1 = completion pending. That read clears the completion bit and releases `irq_n`.
- R10: Power-on reset (`rst_n` low) forces not-ready to 1 and `irq_n` high, and starts the same initialization sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-on reset, active low, asynchronous |
| mod_rst_n | input | 1 | Module reset pin, active low, already synchronous to clk |
| lane_los | input | LANES | Per-lane loss-of-signal events |
| lane_txflt | input | LANES | Per-lane transmit fault events |
| mon_val | input | MON_N*MON_W | Monitored values, monitor m in slice m |
| mon_hi_thr | input | MON_N*MON_W | High alarm thresholds |
| mon_lo_thr | input | MON_N*MON_W | Low alarm thresholds |
| rd_stb | input | 1 | Flag/status register read strobe |
| rd_idx | input | 2 | Register index for the read |
| rd_data | output | GW | Read data, valid in the strobe cycle |
| mask_wr | input | 1 | Mask register write strobe |
| mask_idx | input | 2 | Mask register index (0..2) |
| mask_wdata | input | GW | Mask write data |
| not_ready | output | 1 | Initialization in progress |
| irq_n | output | 1 | Interrupt, active low, drives an open-drain pad |

## Verification
The hardest case to reach is a read that coincides with a still-active event. The read must hand back the bit and keep it set, so the event is held high across the read strobe and the register is read again afterwards. The reset-pin filter boundary is also delicate: the stimulus holds the pin low for exactly RST_MIN_CYC cycles and then for a few more. Between those two pulses, a pending flag and a non-default mask show whether the block reset or not. Readings taken while not-ready is high, with events driven, confirm that the flags stay at zero.

// File: rtl/flag_irq_pkg.sv
package flag_irq_pkg;
    localparam int unsigned IDX_W  = 2;
    localparam int unsigned NUM_GRP = 3;

    typedef enum logic [IDX_W-1:0] {
        GRP_LOS  = 2'd0,
        GRP_TXF  = 2'd1,
        GRP_MON  = 2'd2,
        GRP_STAT = 2'd3
    } grp_e;

    typedef struct packed {
        logic done;
        logic irq_n;
    } top_st_t;
endpackage

// File: rtl/fic_event_cond.sv
module fic_event_cond
    import flag_irq_pkg::*;
#(
    parameter int unsigned LANES = 4,
    parameter int unsigned MON_N = 2,
    parameter int unsigned MON_W = 16,
    parameter int unsigned GW    = 4
) (
    input  logic [LANES-1:0]          lane_los,
    input  logic [LANES-1:0]          lane_txflt,
    input  logic [MON_N*MON_W-1:0]    mon_val,
    input  logic [MON_N*MON_W-1:0]    mon_hi_thr,
    input  logic [MON_N*MON_W-1:0]    mon_lo_thr,
    output logic [NUM_GRP-1:0][GW-1:0] ev
);
    localparam int unsigned MON_BITS = 2 * MON_N;

    logic [MON_BITS-1:0] mon_ev;

    for (genvar m = 0; m < MON_N; m++) begin : g_mon
        logic [MON_W-1:0] val_m;
        logic [MON_W-1:0] hi_m;
        logic [MON_W-1:0] lo_m;
        assign val_m = mon_val[m*MON_W +: MON_W];
        assign hi_m  = mon_hi_thr[m*MON_W +: MON_W];
        assign lo_m  = mon_lo_thr[m*MON_W +: MON_W];
        assign mon_ev[2*m]   = (val_m > hi_m);
        assign mon_ev[2*m+1] = (val_m < lo_m);
    end

    assign ev[GRP_LOS] = GW'(lane_los);
    assign ev[GRP_TXF] = GW'(lane_txflt);
    assign ev[GRP_MON] = GW'(mon_ev);
endmodule

// File: rtl/fic_rst_seq.sv
module fic_rst_seq #(
    parameter int unsigned RST_MIN_CYC = 200,
    parameter int unsigned INIT_CYC    = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_n,
    output logic soft_rst,
    output logic init_done,
    output logic not_ready
);
    localparam int unsigned LC_W = $clog2(RST_MIN_CYC + 2);
    localparam int unsigned IC_W = (INIT_CYC > 1) ? $clog2(INIT_CYC) : 1;

    typedef struct packed {
        logic [LC_W-1:0] lowcnt;
        logic [IC_W-1:0] initcnt;
        logic            nr;
    } seq_st_t;

    seq_st_t st_d, st_q;
    logic    done_c;

    assign soft_rst = pin_n && (st_q.lowcnt > LC_W'(RST_MIN_CYC));

    always_comb begin
        st_d   = st_q;
        done_c = 1'b0;
        if (!pin_n) begin
            if (st_q.lowcnt <= LC_W'(RST_MIN_CYC)) begin
                st_d.lowcnt = st_q.lowcnt + 1'b1;
            end
        end else begin
            st_d.lowcnt = '0;
        end
        if (soft_rst) begin
            st_d.nr      = 1'b1;
            st_d.initcnt = '0;
        end else if (st_q.nr) begin
            if (st_q.initcnt == IC_W'(INIT_CYC - 1)) begin
                st_d.nr = 1'b0;
                done_c  = 1'b1;
            end else begin
                st_d.initcnt = st_q.initcnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{lowcnt: '0, initcnt: '0, nr: 1'b1};
        end else begin
            st_q <= st_d;
        end
    end

    assign init_done = done_c;
    assign not_ready = st_q.nr;
endmodule

// File: rtl/fic_flag_bank.sv
module fic_flag_bank
    import flag_irq_pkg::*;
#(
    parameter int unsigned GW       = 4,
    parameter logic [GW-1:0] MASK_DEF = '0
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NUM_GRP-1:0][GW-1:0] ev,
    input  logic                       hold,
    input  logic                       soft_rst,
    input  logic                       rd_stb,
    input  logic [IDX_W-1:0]           rd_idx,
    input  logic                       mask_wr,
    input  logic [IDX_W-1:0]           mask_idx,
    input  logic [GW-1:0]              mask_wdata,
    output logic [NUM_GRP-1:0][GW-1:0] flags_q,
    output logic [NUM_GRP-1:0][GW-1:0] masks_q,
    output logic [GW-1:0]              rd_flags
);
    typedef struct packed {
        logic [NUM_GRP-1:0][GW-1:0] flags;
        logic [NUM_GRP-1:0][GW-1:0] masks;
    } bank_st_t;

    bank_st_t                   st_d, st_q;
    logic [NUM_GRP-1:0][GW-1:0] clr;

    for (genvar g = 0; g < NUM_GRP; g++) begin : g_clr
        assign clr[g] = (rd_stb && (rd_idx == IDX_W'(g))) ? st_q.flags[g] : '0;
    end

    always_comb begin
        rd_flags = '0;
        for (int g = 0; g < NUM_GRP; g++) begin
            if (rd_stb && (rd_idx == IDX_W'(g))) begin
                rd_flags = st_q.flags[g];
            end
        end
    end

    always_comb begin
        st_d = st_q;
        if (soft_rst) begin
            st_d.flags = '0;
            st_d.masks = {NUM_GRP{MASK_DEF}};
        end else begin
            for (int g = 0; g < NUM_GRP; g++) begin
                if (mask_wr && (mask_idx == IDX_W'(g))) begin
                    st_d.masks[g] = mask_wdata;
                end
                st_d.flags[g] = hold ? '0 : ((st_q.flags[g] & ~clr[g]) | ev[g]);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{flags: '0, masks: {NUM_GRP{MASK_DEF}}};
        end else begin
            st_q <= st_d;
        end
    end

    assign flags_q = st_q.flags;
    assign masks_q = st_q.masks;
endmodule

// File: rtl/flag_irq_ctrl.sv
module flag_irq_ctrl
    import flag_irq_pkg::*;
#(
    parameter int unsigned LANES       = 4,
    parameter int unsigned MON_N       = 2,
    parameter int unsigned MON_W       = 16,
    parameter int unsigned RST_MIN_CYC = 200,
    parameter int unsigned INIT_CYC    = 64,
    parameter int unsigned MASK_DEF    = 0,
    localparam int unsigned GW0 = (LANES > 2 * MON_N) ? LANES : 2 * MON_N,
    localparam int unsigned GW  = (GW0 < 2) ? 2 : GW0
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   mod_rst_n,
    input  logic [LANES-1:0]       lane_los,
    input  logic [LANES-1:0]       lane_txflt,
    input  logic [MON_N*MON_W-1:0] mon_val,
    input  logic [MON_N*MON_W-1:0] mon_hi_thr,
    input  logic [MON_N*MON_W-1:0] mon_lo_thr,
    input  logic                   rd_stb,
    input  logic [1:0]             rd_idx,
    output logic [GW-1:0]          rd_data,
    input  logic                   mask_wr,
    input  logic [1:0]             mask_idx,
    input  logic [GW-1:0]          mask_wdata,
    output logic                   not_ready,
    output logic                   irq_n
);
    localparam logic [GW-1:0] MASK_DEF_V = GW'(MASK_DEF);

    logic [NUM_GRP-1:0][GW-1:0] ev;
    logic [NUM_GRP-1:0][GW-1:0] flags_q;
    logic [NUM_GRP-1:0][GW-1:0] masks_q;
    logic [GW-1:0]              rd_flags;
    logic                       soft_rst;
    logic                       init_done;
    logic                       stat_rd;
    logic                       pend;
    top_st_t                    st_d, st_q;

    fic_event_cond #(
        .LANES(LANES), .MON_N(MON_N), .MON_W(MON_W), .GW(GW)
    ) u_cond (
        .lane_los  (lane_los),
        .lane_txflt(lane_txflt),
        .mon_val   (mon_val),
        .mon_hi_thr(mon_hi_thr),
        .mon_lo_thr(mon_lo_thr),
        .ev        (ev)
    );

    fic_rst_seq #(
        .RST_MIN_CYC(RST_MIN_CYC), .INIT_CYC(INIT_CYC)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin_n    (mod_rst_n),
        .soft_rst (soft_rst),
        .init_done(init_done),
        .not_ready(not_ready)
    );

    fic_flag_bank #(
        .GW(GW), .MASK_DEF(MASK_DEF_V)
    ) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .ev        (ev),
        .hold      (not_ready),
        .soft_rst  (soft_rst),
        .rd_stb    (rd_stb),
        .rd_idx    (rd_idx),
        .mask_wr   (mask_wr),
        .mask_idx  (mask_idx),
        .mask_wdata(mask_wdata),
        .flags_q   (flags_q),
        .masks_q   (masks_q),
        .rd_flags  (rd_flags)
    );

    assign stat_rd = rd_stb && (rd_idx == GRP_STAT);
    assign pend    = |(flags_q & ~masks_q);

    always_comb begin
        if (stat_rd) begin
            rd_data = GW'({st_q.done, not_ready});
        end else begin
            rd_data = rd_flags;
        end
    end

    always_comb begin
        st_d = st_q;
        if (soft_rst) begin
            st_d.done = 1'b0;
        end else if (init_done) begin
            st_d.done = 1'b1;
        end else if (stat_rd) begin
            st_d.done = 1'b0;
        end
        st_d.irq_n = soft_rst ? 1'b1 : ~(pend | st_q.done);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{done: 1'b0, irq_n: 1'b1};
        end else begin
            st_q <= st_d;
        end
    end

    assign irq_n = st_q.irq_n;
endmodule

// File: rtl/flag_irq_ctrl_chk.sv
module flag_irq_ctrl_chk
    import flag_irq_pkg::*;
#(
    parameter int unsigned GW = 4,
    parameter logic [GW-1:0] MASK_DEF = '0
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   irq_n,
    input logic                   not_ready,
    input logic                   soft_rst,
    input logic                   rd_stb,
    input logic [IDX_W-1:0]       rd_idx,
    input logic [GW-1:0]          rd_data,
    input logic [NUM_GRP*GW-1:0]  flags,
    input logic [NUM_GRP*GW-1:0]  masks,
    input logic [NUM_GRP*GW-1:0]  ev
);
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_stb && !soft_rst && !not_ready) |=> ((flags & $past(flags)) == $past(flags))); // R1

    for (genvar g = 0; g < NUM_GRP; g++) begin : g_rd
        AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_stb && rd_idx == IDX_W'(g) && !not_ready && !soft_rst)
            |=> (flags[g*GW +: GW] == $past(ev[g*GW +: GW]))); // R2
    end

    AST_IRQ_ON_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        ((|(flags & ~masks)) && !soft_rst) |=> !irq_n); // R5

    AST_NOT_READY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        not_ready |-> (irq_n && flags == '0)); // R8

    AST_NR_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (not_ready && rd_stb && rd_idx != GRP_STAT) |-> (rd_data == '0)); // R8

    AST_DONE_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(not_ready) && !soft_rst) |=> !irq_n); // R9

    AST_PIN_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (not_ready && flags == '0 && masks == {NUM_GRP{MASK_DEF}})); // R7
endmodule

bind flag_irq_ctrl flag_irq_ctrl_chk #(
    .GW(GW), .MASK_DEF(MASK_DEF_V)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .irq_n    (irq_n),
    .not_ready(not_ready),
    .soft_rst (soft_rst),
    .rd_stb   (rd_stb),
    .rd_idx   (rd_idx),
    .rd_data  (rd_data),
    .flags    (flags_q),
    .masks    (masks_q),
    .ev       (ev)
);

// File: tb/flag_irq_ctrl_tb.sv
module flag_irq_ctrl_tb;
    localparam int CLK_PERIOD = 10;
    localparam int LANES = 4;
    localparam int MON_N = 2;
    localparam int MON_W = 8;
    localparam int RST_MIN = 5;
    localparam int INIT = 10;
    localparam int GW = 4;

    logic                   clk = 1'b0;
    logic                   rst_n = 1'b0;
    logic                   mod_rst_n = 1'b1;
    logic [LANES-1:0]       lane_los = '0;
    logic [LANES-1:0]       lane_txflt = '0;
    logic [MON_N*MON_W-1:0] mon_val = {8'd100, 8'd60};
    logic [MON_N*MON_W-1:0] mon_hi_thr = {8'd200, 8'd100};
    logic [MON_N*MON_W-1:0] mon_lo_thr = {8'd50, 8'd20};
    logic                   rd_stb = 1'b0;
    logic [1:0]             rd_idx = '0;
    logic [GW-1:0]          rd_data;
    logic                   mask_wr = 1'b0;
    logic [1:0]             mask_idx = '0;
    logic [GW-1:0]          mask_wdata = '0;
    logic                   not_ready;
    logic                   irq_n;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    flag_irq_ctrl #(
        .LANES(LANES), .MON_N(MON_N), .MON_W(MON_W),
        .RST_MIN_CYC(RST_MIN), .INIT_CYC(INIT), .MASK_DEF(0)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .mod_rst_n(mod_rst_n),
        .lane_los(lane_los), .lane_txflt(lane_txflt),
        .mon_val(mon_val), .mon_hi_thr(mon_hi_thr), .mon_lo_thr(mon_lo_thr),
        .rd_stb(rd_stb), .rd_idx(rd_idx), .rd_data(rd_data),
        .mask_wr(mask_wr), .mask_idx(mask_idx), .mask_wdata(mask_wdata),
        .not_ready(not_ready), .irq_n(irq_n)
    );

    task automatic chk(input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", what, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic do_read(input logic [1:0] idx, output logic [GW-1:0] val);
        @(negedge clk);
        rd_stb = 1'b1;
        rd_idx = idx;
        #1 val = rd_data;
        @(negedge clk);
        rd_stb = 1'b0;
    endtask

    task automatic do_mask(input logic [1:0] idx, input logic [GW-1:0] val);
        @(negedge clk);
        mask_wr = 1'b1;
        mask_idx = idx;
        mask_wdata = val;
        @(negedge clk);
        mask_wr = 1'b0;
    endtask

    task automatic wait_ready();
        int n = 0;
        while (not_ready && n < 4 * INIT) begin
            @(negedge clk);
            n++;
        end
        chk("R9 not_ready falls after init", int'(not_ready), 0);
        chk("R9 init length within bound", int'(n <= INIT + 2), 1);
    endtask

    task automatic t_powerup();
        logic [GW-1:0] v;
        cyc(2);
        chk("R10 not_ready in reset", int'(not_ready), 1);
        chk("R10 irq_n high in reset", int'(irq_n), 1);
        @(negedge clk);
        rst_n = 1'b1;
        cyc(2);
        chk("R10 not_ready after reset", int'(not_ready), 1);
        lane_los = 4'b1111;
        cyc(1);
        do_read(2'd0, v);
        chk("R8 read zero while not ready", int'(v), 0);
        chk("R8 irq_n high while not ready", int'(irq_n), 1);
        lane_los = '0;
        wait_ready();
        cyc(1);
        chk("R9 completion irq", int'(irq_n), 0);
        do_read(2'd3, v);
        chk("R9 status done=1 nr=0", int'(v), 2);
        cyc(1);
        chk("R9 irq released by status read", int'(irq_n), 1);
        do_read(2'd0, v);
        chk("R8 events during not ready ignored", int'(v), 0);
    endtask

    task automatic t_sticky();
        logic [GW-1:0] v;
        @(negedge clk); lane_los = 4'b0100;
        @(negedge clk); lane_los = '0;
        cyc(1);
        chk("R5 irq after flag", int'(irq_n), 0);
        cyc(3);
        chk("R1 irq held after event gone", int'(irq_n), 0);
        do_read(2'd0, v);
        chk("R1 sticky flag read", int'(v), 4);
        cyc(1);
        chk("R5 irq released after clear", int'(irq_n), 1);
        do_read(2'd0, v);
        chk("R2 flag cleared by read", int'(v), 0);
    endtask

    task automatic t_same_cycle();
        logic [GW-1:0] v;
        @(negedge clk); lane_txflt = 4'b0010;
        do_read(2'd1, v);
        chk("R2 read returns txflt", int'(v), 2);
        lane_txflt = '0;
        do_read(2'd1, v);
        chk("R2 event in read cycle stays", int'(v), 2);
        do_read(2'd1, v);
        chk("R2 cleared on later read", int'(v), 0);
        cyc(1);
    endtask

    task automatic t_isolation();
        logic [GW-1:0] v;
        @(negedge clk); lane_los = 4'b0001; lane_txflt = 4'b1000;
        @(negedge clk); lane_los = '0; lane_txflt = '0;
        do_read(2'd0, v);
        chk("R3 los group read", int'(v), 1);
        do_read(2'd1, v);
        chk("R3 txflt untouched by los read", int'(v), 8);
        cyc(1);
    endtask

    task automatic t_mask();
        logic [GW-1:0] v;
        do_mask(2'd0, 4'b0001);
        @(negedge clk); lane_los = 4'b0001;
        @(negedge clk); lane_los = '0;
        cyc(2);
        chk("R4 masked flag no irq", int'(irq_n), 1);
        do_mask(2'd0, 4'b0000);
        cyc(1);
        chk("R4 unmask raises irq", int'(irq_n), 0);
        do_read(2'd0, v);
        chk("R4 masked flag still latched", int'(v), 1);
        cyc(1);
        chk("R5 irq released", int'(irq_n), 1);
    endtask

    task automatic t_monitor();
        logic [GW-1:0] v;
        @(negedge clk); mon_val = {8'd50, 8'd100};
        cyc(1);
        do_read(2'd2, v);
        chk("R6 equal thresholds no alarm", int'(v), 0);
        @(negedge clk); mon_val = {8'd49, 8'd101};
        @(negedge clk); mon_val = {8'd100, 8'd60};
        do_read(2'd2, v);
        chk("R6 m0 high and m1 low alarms", int'(v), 9);
        @(negedge clk); mon_val = {8'd201, 8'd19};
        @(negedge clk); mon_val = {8'd100, 8'd60};
        do_read(2'd2, v);
        chk("R6 m0 low and m1 high alarms", int'(v), 6);
        do_read(2'd2, v);
        chk("R6 monitor flags cleared", int'(v), 0);
        cyc(1);
    endtask

    task automatic t_short_pin();
        logic [GW-1:0] v;
        @(negedge clk); lane_los = 4'b0010;
        @(negedge clk); lane_los = '0;
        @(negedge clk); mod_rst_n = 1'b0;
        cyc(RST_MIN - 1);
        @(negedge clk); mod_rst_n = 1'b1;
        cyc(3);
        chk("R7 short pulse keeps ready", int'(not_ready), 0);
        chk("R7 short pulse keeps irq", int'(irq_n), 0);
        do_read(2'd0, v);
        chk("R7 short pulse keeps flag", int'(v), 2);
        cyc(1);
    endtask

    task automatic t_long_pin();
        logic [GW-1:0] v;
        @(negedge clk); lane_los = 4'b1000;
        @(negedge clk); lane_los = '0;
        do_mask(2'd1, 4'b1111);
        @(negedge clk); mod_rst_n = 1'b0;
        cyc(RST_MIN + 2);
        @(negedge clk); mod_rst_n = 1'b1;
        cyc(2);
        chk("R7 long pulse sets not_ready", int'(not_ready), 1);
        chk("R7 long pulse releases irq", int'(irq_n), 1);
        wait_ready();
        cyc(1);
        chk("R9 completion irq after pin reset", int'(irq_n), 0);
        do_read(2'd3, v);
        chk("R9 status after pin reset", int'(v), 2);
        cyc(1);
        chk("R9 irq released", int'(irq_n), 1);
        do_read(2'd0, v);
        chk("R7 flags cleared by pin reset", int'(v), 0);
        @(negedge clk); lane_txflt = 4'b0001;
        @(negedge clk); lane_txflt = '0;
        cyc(1);
        chk("R7 mask back to default", int'(irq_n), 0);
        do_read(2'd1, v);
        chk("R7 txflt after reset", int'(v), 1);
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        t_powerup();
        t_sticky();
        t_same_cycle();
        t_isolation();
        t_mask();
        t_monitor();
        t_short_pin();
        t_long_pin();
        cyc(2);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule